// File: doc/BRIEF.md
# Halt and Sleep Power Controller

This block sequences a processor through its two low-power states and back. A halt command gates off the CPU clock while the peripheral clocks keep running, so timers and serial logic can still raise interrupts. A sleep command gates off both the CPU and the peripheral clocks and treats the oscillator as stopped. When a wake condition arrives, the block brings the clocks back and issues a one-cycle resume pulse that tells the CPU to enter its exception handler.

The two states have different wake sets. Halt ends on any interrupt request. Sleep ends only on a port-input interrupt. After a sleep wake, the CPU is held for an oscillator stabilization wait. The length of that wait depends on which oscillator was selected at the moment sleep was entered: a short wait for the low-speed clock and a long wait for the high-speed clock. A parameter can lengthen both waits by the same number of cycles.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in run. `cpu_clk_en`=1, `periph_clk_en`=1 and `resume_pulse`=0.
- R2: A `halt_cmd` sampled high in run gives `cpu_clk_en`=0 and `periph_clk_en`=1 from the next cycle on. `cpu_clk_en` is never 1 while `periph_clk_en` is 0.
- R3: In halt, `irq_any` or `irq_port` sampled high returns the block to run in the next cycle. That cycle has `cpu_clk_en`=1 and `resume_pulse`=1.
- R4: A `sleep_cmd` sampled high in run gives `cpu_clk_en`=0 and `periph_clk_en`=0 from the next cycle on. If `halt_cmd` is high in the same cycle, sleep takes precedence.
- R5: In sleep, `irq_any` without `irq_port` has no effect. Both enables stay 0 and no resume pulse is issued.
- R6: `irq_port` sampled high in sleep starts the stabilization wait. Both enables stay 0 for exactly N cycles, counted from the cycle after the wake edge. N = `SLOW_WAIT`+`EXTRA_WAIT` (default 128) when `clk_sel_fast` was 0 at sleep entry. N = `FAST_WAIT`+`EXTRA_WAIT` (default 512) when `clk_sel_fast` was 1 at sleep entry.
- R7: `clk_sel_fast` is captured only on the sleep-entry edge. Changing it during sleep or during the wait does not change N.
- R8: When the wait ends, `cpu_clk_en` and `periph_clk_en` both rise in the same cycle as a `resume_pulse` of exactly one cycle.
- R9: Driving `rst_n` low forces run at once, with no clock edge needed, from any state. This abandons any wait in progress. A later sleep wake then waits the full N again.
- R10: `halt_cmd` and `sleep_cmd` are ignored outside run. For example, a sleep command given in halt leaves the block in halt, and the block still wakes on `irq_any`.
- R11: `resume_pulse` is asserted only in the cycle right after leaving halt or the wait, and it is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (oscillator clock once restarted) |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_cmd | input | 1 | Halt instruction executed |
| sleep_cmd | input | 1 | Sleep instruction executed |
| irq_any | input | 1 | Any enabled interrupt request |
| irq_port | input | 1 | Port-input interrupt request |
| clk_sel_fast | input | 1 | 1 = high-speed oscillator in use, 0 = low-speed |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| resume_pulse | output | 1 | One-cycle pulse: CPU resumes in its handler |

## Verification
Every state change and every output appears one clock edge after the input is sampled. The only exceptions are reset, which acts with no edge, and the stabilization wait, which keeps the enables low for N cycles after the wake edge. Inputs are driven on the falling edge. Each check samples one falling edge after the rising edge that consumes the input. The wait is measured by counting the sampled cycles in which `cpu_clk_en` stays low, starting at the sample right after the wake edge. That count is compared with N. The resume pulse is checked in the cycle where the enables rise, and again one cycle later to confirm it has dropped.

// File: rtl/pwr_standby_pkg.sv
package pwr_standby_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_HALT  = 2'd1,
      PS_SLEEP = 2'd2,
      PS_STAB  = 2'd3
   } pwr_state_e;
endpackage

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
   parameter int SLOW_CYC = 128,
   parameter int FAST_CYC = 512,
   parameter int CNT_W    = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_sel,
   input  logic sel_fast_in,
   input  logic load,
   input  logic run,
   output logic wait_done
);
   logic             sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] preload;

   // Oscillator choice captured at sleep entry only.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sel_q <= 1'b0;
      else if (capture_sel) sel_q <= sel_fast_in;
   end

   generate
      if (SLOW_CYC == FAST_CYC) begin : g_single_len
         assign preload = CNT_W'(SLOW_CYC - 1);
      end else begin : g_dual_len
         assign preload = sel_q ? CNT_W'(FAST_CYC - 1) : CNT_W'(SLOW_CYC - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load)                    cnt_q <= preload;
      else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign wait_done = (cnt_q == '0);

   // R6: the counter steps down by one every cycle of the wait.
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R7: the captured selection holds except on the entry edge.
   p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture_sel) |=> $stable(sel_q));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_standby_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_cmd,
   input  logic       sleep_cmd,
   input  logic       wake_halt,
   input  logic       wake_sleep,
   input  logic       wait_done,
   output pwr_state_e state_q,
   output logic       resume_q
);
   pwr_state_e state_d;
   logic       resume_d;

   always_comb begin
      state_d  = state_q;
      resume_d = 1'b0;
      unique case (state_q)
         PS_RUN: begin
            if (sleep_cmd)     state_d = PS_SLEEP;
            else if (halt_cmd) state_d = PS_HALT;
         end
         PS_HALT: begin
            if (wake_halt) begin
               state_d  = PS_RUN;
               resume_d = 1'b1;
            end
         end
         PS_SLEEP: begin
            if (wake_sleep) state_d = PS_STAB;
         end
         PS_STAB: begin
            if (wait_done) begin
               state_d  = PS_RUN;
               resume_d = 1'b1;
            end
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PS_RUN;
         resume_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         resume_q <= resume_d;
      end
   end

   // R5: sleep is left only through a port wake.
   p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SLEEP && !wake_sleep) |=> (state_q == PS_SLEEP));

   // R11: the resume pulse lasts one cycle.
   p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resume_q |=> !resume_q);

   // R8: a resume pulse only appears once back in run.
   p_pulse_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_q |-> (state_q == PS_RUN));

   // R10: commands outside run do not move the block.
   p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_HALT && !wake_halt) |=> (state_q == PS_HALT));
endmodule

// File: rtl/pwr_wake_gate.sv
module pwr_wake_gate
   import pwr_standby_pkg::*;
#(
   parameter bit PORT_WAKES_HALT = 1'b1
) (
   input  pwr_state_e state,
   input  logic       irq_any,
   input  logic       irq_port,
   output logic       wake_halt,
   output logic       wake_sleep,
   output logic       cpu_clk_en,
   output logic       periph_clk_en
);
   generate
      if (PORT_WAKES_HALT) begin : g_halt_wake_both
         assign wake_halt = irq_any | irq_port;
      end else begin : g_halt_wake_any
         assign wake_halt = irq_any;
      end
   endgenerate

   assign wake_sleep    = irq_port;
   assign cpu_clk_en    = (state == PS_RUN);
   assign periph_clk_en = (state == PS_RUN) || (state == PS_HALT);
endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl
   import pwr_standby_pkg::*;
#(
   parameter int SLOW_WAIT  = 128,
   parameter int FAST_WAIT  = 512,
   parameter int EXTRA_WAIT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_cmd,
   input  logic sleep_cmd,
   input  logic irq_any,
   input  logic irq_port,
   input  logic clk_sel_fast,
   output logic cpu_clk_en,
   output logic periph_clk_en,
   output logic resume_pulse
);
   localparam int SLOW_TOT = SLOW_WAIT + EXTRA_WAIT;
   localparam int FAST_TOT = FAST_WAIT + EXTRA_WAIT;
   localparam int MAX_TOT  = (SLOW_TOT > FAST_TOT) ? SLOW_TOT : FAST_TOT;
   localparam int CNT_W    = (MAX_TOT > 1) ? $clog2(MAX_TOT) : 1;

   generate
      if (SLOW_WAIT < 1 || FAST_WAIT < 1) begin : g_bad_wait
         $error("stabilization waits must be at least one cycle");
      end
      if (EXTRA_WAIT < 0) begin : g_bad_extra
         $error("extra wait must not be negative");
      end
   endgenerate

   pwr_state_e state;
   logic       wake_halt, wake_sleep, wait_done;
   logic       enter_sleep, start_wait, in_wait;

   assign enter_sleep = (state == PS_RUN) && sleep_cmd;
   assign start_wait  = (state == PS_SLEEP) && wake_sleep;
   assign in_wait     = (state == PS_STAB);

   pwr_wake_gate #(.PORT_WAKES_HALT(1'b1)) u_gate (
      .state         (state),
      .irq_any       (irq_any),
      .irq_port      (irq_port),
      .wake_halt     (wake_halt),
      .wake_sleep    (wake_sleep),
      .cpu_clk_en    (cpu_clk_en),
      .periph_clk_en (periph_clk_en)
   );

   pwr_stab_timer #(.SLOW_CYC(SLOW_TOT), .FAST_CYC(FAST_TOT), .CNT_W(CNT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_sel (enter_sleep),
      .sel_fast_in (clk_sel_fast),
      .load        (start_wait),
      .run         (in_wait),
      .wait_done   (wait_done)
   );

   pwr_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_cmd   (halt_cmd),
      .sleep_cmd  (sleep_cmd),
      .wake_halt  (wake_halt),
      .wake_sleep (wake_sleep),
      .wait_done  (wait_done),
      .state_q    (state),
      .resume_q   (resume_pulse)
   );

   // R3: a halt wake yields run plus a resume pulse one edge later.
   p_halt_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_HALT && (irq_any || irq_port)) |=> (resume_pulse && cpu_clk_en));

   // R2: the CPU clock never runs without the peripheral clock.
   p_enable_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> periph_clk_en);

   // R6: the wait starts one edge after a port wake in sleep.
   p_wait_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_wait |=> (!periph_clk_en && !cpu_clk_en));

   // R4: sleep entry takes precedence over halt.
   p_sleep_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && sleep_cmd) |=> !periph_clk_en);
endmodule

// File: tb/pwr_standby_ctrl_tb.sv
module pwr_standby_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N_SLOW = 128;
   localparam int N_FAST = 512;
   localparam int NVEC = 11;
   // {halt, sleep, any, port, sel, exp_cpu, exp_periph, exp_pulse}
   localparam logic [7:0] VEC [NVEC] = '{
      8'b00000_110, // R1 idle in run
      8'b10000_010, // R2 halt
      8'b01000_010, // R10 sleep ignored in halt
      8'b00000_010, // R2 stays halted
      8'b00100_111, // R3 wake on any interrupt
      8'b00000_110, // R11 pulse dropped
      8'b11000_000, // R4 sleep wins over halt
      8'b00100_000, // R5 any irq ignored in sleep
      8'b10000_000, // R10 halt ignored in sleep
      8'b00000_000, // R5 still asleep
      8'b00010_000  // R6 port wake, slow wait begins
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_cmd = 0, sleep_cmd = 0, irq_any = 0, irq_port = 0, clk_sel_fast = 0;
   logic cpu_clk_en, periph_clk_en, resume_pulse;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_standby_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .sleep_cmd(sleep_cmd),
      .irq_any(irq_any), .irq_port(irq_port), .clk_sel_fast(clk_sel_fast),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .resume_pulse(resume_pulse)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      halt_cmd = 0; sleep_cmd = 0; irq_any = 0; irq_port = 0;
   endtask

   // Counts low cpu_clk_en samples starting at the sample after the wake edge.
   task automatic measure_wait(input string req, input int exp_n, input bit flip_sel);
      int lows = 0;
      irq_port = 1'b1;
      tick();
      irq_port = 1'b0;
      if (!cpu_clk_en) lows = 1;
      while (!cpu_clk_en && lows < 2000) begin
         if (flip_sel) clk_sel_fast = ~clk_sel_fast;
         tick();
         if (!cpu_clk_en) lows++;
      end
      check(req, lows, exp_n);
      check("R8 periph enable at resume", int'(periph_clk_en), 1);
      check("R8 pulse at resume", int'(resume_pulse), 1);
      tick();
      check("R11 pulse one cycle", int'(resume_pulse), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1 cpu en in reset", int'(cpu_clk_en), 1);
      check("R1 pulse in reset", int'(resume_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 periph en after reset", int'(periph_clk_en), 1);

      for (int i = 0; i < NVEC; i++) begin
         {halt_cmd, sleep_cmd, irq_any, irq_port, clk_sel_fast} = VEC[i][7:3];
         tick();
         check($sformatf("vec%0d cpu", i), int'(cpu_clk_en), int'(VEC[i][2]));
         check($sformatf("vec%0d periph", i), int'(periph_clk_en), int'(VEC[i][1]));
         check($sformatf("vec%0d pulse", i), int'(resume_pulse), int'(VEC[i][0]));
      end
      idle_inputs();
      // Finish the slow wait already started by the last vector (1 low sample seen).
      begin
         int lows = 1;
         while (!cpu_clk_en && lows < 2000) begin
            tick();
            if (!cpu_clk_en) lows++;
         end
         check("R6 slow wait length", lows, N_SLOW);
         check("R8 pulse at slow resume", int'(resume_pulse), 1);
      end

      // R7: slow entry, select toggled during the wait.
      clk_sel_fast = 0; sleep_cmd = 1; tick(); sleep_cmd = 0;
      clk_sel_fast = 1; tick();
      measure_wait("R7 select change ignored (slow)", N_SLOW, 1'b1);

      // R6/R7: fast entry, select dropped before the wake.
      clk_sel_fast = 1; sleep_cmd = 1; tick(); sleep_cmd = 0;
      clk_sel_fast = 0; tick();
      measure_wait("R6 fast wait length", N_FAST, 1'b0);

      // R9: reset mid-wait acts with no clock edge, then full wait again.
      clk_sel_fast = 0; sleep_cmd = 1; tick(); sleep_cmd = 0;
      irq_port = 1; tick(); irq_port = 0;
      repeat (40) tick();
      check("R9 still waiting before reset", int'(cpu_clk_en), 0);
      #1 rst_n = 1'b0;
      #1 check("R9 async reset to run", int'(cpu_clk_en), 1);
      check("R9 periph on at reset", int'(periph_clk_en), 1);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      check("R9 pulse not issued by reset", int'(resume_pulse), 0);
      sleep_cmd = 1; tick(); sleep_cmd = 0;
      measure_wait("R9 full wait after abandon", N_SLOW, 1'b0);

      // R3: port interrupt also wakes halt.
      halt_cmd = 1; tick(); halt_cmd = 0;
      check("R2 halted cpu off", int'(cpu_clk_en), 0);
      irq_port = 1; tick(); irq_port = 0;
      check("R3 port wakes halt", int'(cpu_clk_en), 1);
      check("R3 pulse on halt wake", int'(resume_pulse), 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule